// File: doc/BRIEF.md
# Masked Find-First Mask Generator

This block turns a source bit-vector into a mask built around its lowest set bit. A mode input selects one of three shapes. "Before" sets every element under the first one. "Through" also sets the first one itself. "Single" sets only the first one. Element 0 is the least significant bit, and the search runs toward higher indices.

An element-enable vector, gated by a mask-enable input, picks the elements that take part. Source bits in disabled positions are cleared before the search, so they can never be the first one. Disabled output positions are copied from an old-destination input.

Each operation is presented with a valid pulse. Its result is captured in an output register and appears one cycle later together with a valid flag.

Top module: `ffm_unit`

## Requirements
- R1: Mode 2'b00 ("before"): each active element whose index is below the lowest active set source bit gets 1. That element and every active element above it get 0.
- R2: Mode 2'b00 with no active source bit set: every active element gets 1.
- R3: Mode 2'b01 ("through"): the result equals mode 2'b00, except that the element holding the lowest active set bit is also 1.
- R4: Mode 2'b10 ("single"): only the element holding the lowest active set bit is 1, and all other active elements are 0. If no active bit is set, all active elements are 0.
- R5: When the mask is in force, a set source bit in a disabled position has no effect on the search.
- R6: When the mask is in force, every disabled output position equals the corresponding bit of the old-destination input.
- R7: With mask_en low, every element is active regardless of en_mask. For example, source 10010100 gives 00000011, 00000111 and 00000100 in modes 00, 01 and 10.
- R8: Mode 2'b11 is reserved and returns the old-destination input unchanged.
- R9: result and valid_out update on the clock edge at which valid_in is sampled high, so valid_out follows valid_in by one cycle. A synchronous active-high reset clears valid_out and result.
- R10: While valid_in is low, result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation request for this cycle |
| mode | input | 2 | 00 before, 01 through, 10 single, 11 reserved |
| mask_en | input | 1 | 1: en_mask selects the active elements; 0: all elements are active |
| en_mask | input | VLEN | Element enables |
| src | input | VLEN | Source vector |
| old_dst | input | VLEN | Previous destination value, kept in disabled positions |
| valid_out | output | 1 | Result valid |
| result | output | VLEN | Registered mask result |

## Verification
The masked search and the merge with the old destination act in the same cycle whenever the mask is in force. A disabled set source bit then sits below the first enabled set bit, while disabled output positions have to retain old data. The bench provokes this with directed vectors in which the disabled bits are chosen to disagree with the active result. Random vectors with mask_en high do the same. Each outcome is judged bit by bit against a scan model in the bench, which treats active and retained positions separately.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
   typedef enum logic [1:0] {
      MODE_BEFORE  = 2'b00,
      MODE_THROUGH = 2'b01,
      MODE_SINGLE  = 2'b10,
      MODE_RSVD    = 2'b11
   } ffm_mode_e;
endpackage

// File: rtl/ffm_gate.sv
// Derives the active-element vector and clears inactive source bits.
module ffm_gate #(
   parameter int VLEN = 8
) (
   input  logic            mask_en,
   input  logic [VLEN-1:0] en_mask,
   input  logic [VLEN-1:0] src,
   output logic [VLEN-1:0] active,
   output logic [VLEN-1:0] src_act
);
   always_comb begin
      active  = mask_en ? en_mask : {VLEN{1'b1}};
      src_act = src & active;
   end
endmodule

// File: rtl/ffm_first_one.sv
// Lowest-set-bit search: one-hot of the first one and the run of zeros below it.
module ffm_first_one #(
   parameter int VLEN  = 8,
   parameter bit ARITH = 1'b1
) (
   input  logic [VLEN-1:0] x,
   output logic [VLEN-1:0] first,
   output logic [VLEN-1:0] below
);
   if (ARITH) begin : g_arith
      // two's complement carry isolates the lowest one
      always_comb begin
         first = x & (~x + {{(VLEN-1){1'b0}}, 1'b1});
         below = ~x & (x - {{(VLEN-1){1'b0}}, 1'b1});
      end
   end else begin : g_ripple
      always_comb begin
         logic seen;
         seen = 1'b0;
         for (int i = 0; i < VLEN; i++) begin
            first[i] = !seen && x[i];
            below[i] = !seen && !x[i];
            seen     = seen | x[i];
         end
      end
   end

   always_comb begin
      p_first_onehot_r4 : assert ($onehot0(first));
      p_first_below_disjoint_r1 : assert ((first & below) == '0);
   end
endmodule

// File: rtl/ffm_merge.sv
// Shapes the mask per mode and keeps old bits in inactive positions.
module ffm_merge
   import ffm_pkg::*;
#(
   parameter int VLEN = 8
) (
   input  ffm_mode_e       mode,
   input  logic [VLEN-1:0] active,
   input  logic [VLEN-1:0] first,
   input  logic [VLEN-1:0] below,
   input  logic [VLEN-1:0] old_dst,
   output logic [VLEN-1:0] merged
);
   logic [VLEN-1:0] shaped;

   always_comb begin
      unique case (mode)
         MODE_BEFORE:  shaped = below;
         MODE_THROUGH: shaped = below | first;
         MODE_SINGLE:  shaped = first;
         default:      shaped = old_dst;
      endcase
      merged = (shaped & active) | (old_dst & ~active);
   end
endmodule

// File: rtl/ffm_unit.sv
module ffm_unit
   import ffm_pkg::*;
#(
   parameter int VLEN  = 8,
   parameter bit ARITH = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid_in,
   input  logic [1:0]      mode,
   input  logic            mask_en,
   input  logic [VLEN-1:0] en_mask,
   input  logic [VLEN-1:0] src,
   input  logic [VLEN-1:0] old_dst,
   output logic            valid_out,
   output logic [VLEN-1:0] result
);
   localparam logic [VLEN-1:0] ZERO = '0;

   if (VLEN < 2) begin : g_bad_vlen
      $error("ffm_unit: VLEN must be at least 2");
   end

   logic [VLEN-1:0] active, src_act, first, below, merged;
   ffm_mode_e       mode_e;

   assign mode_e = ffm_mode_e'(mode);

   ffm_gate #(.VLEN(VLEN)) u_gate (
      .mask_en(mask_en), .en_mask(en_mask), .src(src),
      .active(active), .src_act(src_act)
   );

   ffm_first_one #(.VLEN(VLEN), .ARITH(ARITH)) u_find (
      .x(src_act), .first(first), .below(below)
   );

   ffm_merge #(.VLEN(VLEN)) u_merge (
      .mode(mode_e), .active(active), .first(first), .below(below),
      .old_dst(old_dst), .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out <= 1'b0;
         result    <= ZERO;
      end else begin
         valid_out <= valid_in;
         if (valid_in) result <= merged;
      end
   end

   p_valid_rise_r9 : assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
   p_valid_fall_r9 : assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);
   p_hold_r10 : assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(result));
   p_keep_disabled_r6 : assert property (@(posedge clk) disable iff (rst)
      (valid_in && mask_en) |=>
      (((result ^ $past(old_dst)) & ~$past(en_mask)) == ZERO));
   p_reserved_r8 : assert property (@(posedge clk) disable iff (rst)
      (valid_in && mode == 2'b11) |=> (result == $past(old_dst)));
   p_single_onehot_r4 : assert property (@(posedge clk) disable iff (rst)
      (valid_in && mode == 2'b10) |=> ($countones(result & $past(active)) <= 1));
endmodule

// File: tb/ffm_unit_test.sv
module ffm_unit_test;
   localparam int VLEN = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            valid_in = 1'b0;
   logic [1:0]      mode = 2'b00;
   logic            mask_en = 1'b0;
   logic [VLEN-1:0] en_mask = '0, src = '0, old_dst = '0;
   logic            valid_out;
   logic [VLEN-1:0] result;

   int n_checks = 0, n_fail = 0;

   ffm_unit #(.VLEN(VLEN)) uut (
      .clk(clk), .rst(rst), .valid_in(valid_in), .mode(mode),
      .mask_en(mask_en), .en_mask(en_mask), .src(src), .old_dst(old_dst),
      .valid_out(valid_out), .result(result)
   );

   always #10 clk = ~clk;   // 50 MHz

   function automatic logic [VLEN-1:0] model(input logic [1:0] m, input logic me,
         input logic [VLEN-1:0] en, input logic [VLEN-1:0] s, input logic [VLEN-1:0] od);
      logic [VLEN-1:0] r;
      logic seen;
      seen = 1'b0;
      r = od;
      if (m == 2'b11) return od;
      for (int i = 0; i < VLEN; i++) begin
         if (!me || en[i]) begin
            case (m)
               2'b00: r[i] = !seen && !s[i];
               2'b01: r[i] = !seen;
               default: r[i] = !seen && s[i];
            endcase
            if (s[i]) seen = 1'b1;
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [1:0] m, input logic me,
         input logic [VLEN-1:0] en, input logic [VLEN-1:0] s, input logic [VLEN-1:0] od);
      @(negedge clk);
      valid_in = 1'b1; mode = m; mask_en = me; en_mask = en; src = s; old_dst = od;
      @(negedge clk);
      check({tag, " valid_out"}, {7'b0, valid_out}, 8'd1);
      check(tag, result, model(m, me, en, s, od));
      valid_in = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      logic [VLEN-1:0] held;
      void'($urandom(32'd2024));
      repeat (2) @(negedge clk);
      check("R9 reset valid_out", {7'b0, valid_out}, 8'd0);
      check("R9 reset result", result, 8'h00);
      rst = 1'b0;

      // R7: mask off, en_mask deliberately all zero
      run("R1 R7 before", 2'b00, 1'b0, 8'h00, 8'b10010100, 8'h5A);
      check("R1 literal", result, 8'b00000011);
      run("R3 R7 through", 2'b01, 1'b0, 8'h00, 8'b10010100, 8'h5A);
      check("R3 literal", result, 8'b00000111);
      run("R4 R7 single", 2'b10, 1'b0, 8'h00, 8'b10010100, 8'h5A);
      check("R4 literal", result, 8'b00000100);
      run("R1 bit0 set", 2'b00, 1'b0, 8'h00, 8'b10010101, 8'hFF);
      check("R1 literal2", result, 8'b00000000);
      run("R2 none set", 2'b00, 1'b0, 8'h00, 8'h00, 8'h00);
      check("R2 literal", result, 8'hFF);
      run("R4 none set", 2'b10, 1'b0, 8'h00, 8'h00, 8'hFF);
      check("R4 literal2", result, 8'h00);

      // masked: disabled bit2 set below enabled bit7
      run("R5 R6 before", 2'b00, 1'b1, 8'b11000011, 8'b10010100, 8'b00111100);
      check("R5 literal", result, 8'b01111111);
      run("R5 R6 through", 2'b01, 1'b1, 8'b11000011, 8'b10010100, 8'b00000000);
      check("R3 masked literal", result, 8'b11000011);
      run("R5 single", 2'b10, 1'b1, 8'b11000011, 8'b11010100, 8'b00101000);
      check("R5 single literal", result, 8'b01101000);
      run("R2 masked none", 2'b00, 1'b1, 8'b00001111, 8'b11110000, 8'b10100000);
      check("R2 masked literal", result, 8'b10101111);
      run("R8 reserved", 2'b11, 1'b0, 8'h00, 8'h0F, 8'hC3);
      check("R8 literal", result, 8'hC3);

      // R10: inputs change with valid_in low
      held = result;
      @(negedge clk);
      mode = 2'b00; src = 8'h00; old_dst = 8'h11; mask_en = 1'b0;
      @(negedge clk);
      check("R10 hold", result, held);
      check("R9 idle valid_out", {7'b0, valid_out}, 8'd0);

      for (int k = 0; k < 400; k++) begin
         logic [1:0] m;
         m = 2'($urandom);
         case (m)
            2'b00: run("R1 random", m, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            2'b01: run("R3 random", m, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            2'b10: run("R4 random", m, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            default: run("R8 random", m, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
         endcase
      end

      // R9: reset mid-stream clears the output
      @(negedge clk);
      valid_in = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R9 reset again", {7'b0, valid_out}, 8'd0);
      rst = 1'b0; valid_in = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule